// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

The engine moves outgoing packets from memory to a byte-wide transmitter. Software builds a ring of 8-byte descriptors inside a 1 kB-aligned table and points the engine at it. Each descriptor gives a packet length, a buffer address and a few control flags. When software sets the run bit, the engine reads the descriptor the ring index selects. It then fetches the packet buffer one 32-bit word at a time and streams the bytes out. After the transmitter reports the outcome, the engine writes the first descriptor word back with its ownership flag cleared and the outcome recorded. It raises an interrupt if one was requested and steps to the next descriptor.

Ownership passes through the descriptor's own-flag (bit 11 of word 0). Software sets it last, and the engine clears it on write-back. A descriptor whose flag is clear stops the engine: the run bit drops and the engine waits for software. The ring index steps by one descriptor (8 bytes). It wraps to zero after the last slot of the table, or earlier when the descriptor just used carries its wrap flag.

Register map (select input `reg_addr`): address 0 is control/status, with bit 0 run, bit 1 interrupt enable and bit 2 interrupt status (write one to clear). Address 1 is the ring pointer, with bits 31:10 the table base, bits 9:3 the descriptor index, and bits 2:0 reading as zero. Descriptor word 0 holds length in bits 10:0, own at 11, wrap at 12, interrupt request at 13, underrun at 14 and attempt-limit at 15. Bits 31:16 are written back as zero. Descriptor word 1 holds the buffer address, bits 31:2.

Top module: `txdma_engine`

## Requirements
- R1: After reset the run bit, interrupt enable, interrupt status and ring pointer all read zero, and `mem_req`, `tx_valid` and `irq` are low.
- R2: With run set, the engine reads word 0 at base + index*8 and then word 1 at base + index*8 + 4. Every memory request holds its address and direction until `mem_ack`.
- R3: If the fetched word 0 has bit 11 clear, the engine clears the run bit (control bit 0 reads 0), returns to idle and issues no further memory requests.
- R4: Packet data is read as 32-bit words from the buffer address upward and sent most significant byte first. Exactly `length` bytes are sent, and `tx_last` is high on the final byte only. After the final byte no further byte is offered until the next descriptor.
- R5: On completion word 0 is written back at its own address. Bit 11 is clear, length, wrap (12) and interrupt request (13) are kept, bit 15 equals `done_al`, bit 14 equals `done_ue`, and bits 31:16 are zero.
- R6: After a write-back without the wrap flag, the pointer index advances by one (address +8), and the pointer register reads the next descriptor to be fetched.
- R7: The index returns to zero after the descriptor at index 127 (offset 0x3F8) is used, or after any descriptor whose wrap flag (bit 12) is set.
- R8: Interrupt status sets when a descriptor's write-back completes only if both its bit 13 and control bit 1 are set. This holds whether the packet succeeded or reported an error. `irq` follows the status bit.
- R9: Writing control bit 2 as one clears the interrupt status, and writing it as zero leaves the status unchanged. A completion in the same cycle as a clearing write leaves the status set.
- R10: A descriptor of length zero causes no buffer reads and no stream bytes. It is still written back (with both error bits zero), can raise the interrupt, and advances the pointer.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 ring pointer |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Transmitter accepts the byte |
| done_valid | input | 1 | Transmitter outcome pulse |
| done_al | input | 1 | Attempt limit reached |
| done_ue | input | 1 | FIFO underrun occurred |
| irq | output | 1 | Transmit interrupt (status bit) |

## Verification
Two functions can fall in the same cycle here: the engine setting the interrupt status as a write-back is acknowledged, and software clearing that status through the control register. The bench watches the memory port for the acknowledged write-back. It then asserts a clearing control write in exactly that acknowledge cycle. It judges the result by reading the status back and by `irq`, both of which must stay set. Ring wrap at the final slot, wrap by flag, zero-length descriptors and backpressure on the stream are each driven by their own directed scenario.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 11;

    // Descriptor word 0 flag positions (fixed by the in-memory format)
    localparam int OWN_POS  = 11;
    localparam int WRAP_POS = 12;
    localparam int IRQ_POS  = 13;
    localparam int UNDR_POS = 14;
    localparam int ATTL_POS = 15;

    localparam int DESC_LG = 3;   // 8-byte descriptors

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BUFP,
        ST_FETCH,
        ST_SEND,
        ST_WAIT,
        ST_WBACK
    } eng_state_t;

    typedef struct packed {
        logic             irq_req;
        logic             wrap;
        logic [LEN_W-1:0] len;
    } desc_ctl_t;

    typedef struct packed {
        logic attl;
        logic undr;
    } tx_result_t;

    function automatic desc_ctl_t unpack_ctl(logic [WORD_W-1:0] w);
        desc_ctl_t c;
        c.irq_req = w[IRQ_POS];
        c.wrap    = w[WRAP_POS];
        c.len     = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(desc_ctl_t c, tx_result_t r);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[LEN_W-1:0]   = c.len;
        w[WRAP_POS]    = c.wrap;
        w[IRQ_POS]     = c.irq_req;
        w[UNDR_POS]    = r.undr;
        w[ATTL_POS]    = r.attl;
        return w;
    endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs #(
    parameter int ADDR_W  = 32,
    parameter int RING_AW = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic                      reg_addr,
    input  logic [ADDR_W-1:0]         reg_wdata,
    output logic [ADDR_W-1:0]         reg_rdata,
    input  logic                      stop_req,
    input  logic                      adv_req,
    input  logic                      adv_wrap,
    input  logic                      irq_set,
    output logic                      run,
    output logic                      irq_en,
    output logic                      irq_st,
    output logic [ADDR_W-1:RING_AW]   ring_base,
    output logic [RING_AW-1:txdma_pkg::DESC_LG] ring_idx
);
    import txdma_pkg::*;

    localparam int IDX_W = RING_AW - DESC_LG;

    logic wr_ctl, wr_ptr;
    assign wr_ctl = reg_wr && !reg_addr;
    assign wr_ptr = reg_wr &&  reg_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            irq_en    <= 1'b0;
            irq_st    <= 1'b0;
            ring_base <= '0;
            ring_idx  <= '0;
        end else begin
            if (wr_ctl) begin
                run    <= reg_wdata[0];
                irq_en <= reg_wdata[1];
            end else if (stop_req) begin
                run <= 1'b0;
            end

            // set has priority over a write-one clear
            if (irq_set)
                irq_st <= 1'b1;
            else if (wr_ctl && reg_wdata[2])
                irq_st <= 1'b0;

            if (wr_ptr)
                ring_base <= reg_wdata[ADDR_W-1:RING_AW];

            if (adv_req)
                ring_idx <= adv_wrap ? '0 : IDX_W'(ring_idx + 1'b1);
            else if (wr_ptr)
                ring_idx <= reg_wdata[RING_AW-1:DESC_LG];
        end
    end

    always_comb begin
        if (reg_addr)
            reg_rdata = {ring_base, ring_idx, {DESC_LG{1'b0}}};
        else
            reg_rdata = ADDR_W'({irq_st, irq_en, run});
    end

endmodule

// File: rtl/txdma_bytes.sv
module txdma_bytes #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_load,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              word_load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              beat,
    output logic [7:0]        byte_out,
    output logic              is_last,
    output logic              word_end
);
    localparam int NB = WORD_W / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     bidx;
    logic [LEN_W-1:0]  remain;
    logic [WORD_W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            bidx   <= '0;
            remain <= '0;
        end else begin
            if (len_load)
                remain <= len_in;
            else if (beat)
                remain <= remain - 1'b1;

            if (word_load) begin
                word_q <= word_in;
                bidx   <= '0;
            end else if (beat) begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    assign shifted  = word_q << {bidx, 3'b000};
    assign byte_out = shifted[WORD_W-1 -: 8];
    assign is_last  = (remain == LEN_W'(1));
    assign word_end = (bidx == IW'(NB - 1));

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine #(
    parameter int ADDR_W  = 32,
    parameter int RING_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              done_valid,
    input  logic              done_al,
    input  logic              done_ue,
    output logic              irq
);
    import txdma_pkg::*;

    localparam int IDX_W = RING_AW - DESC_LG;
    localparam int WP_W  = ADDR_W - 2;

    eng_state_t state;
    desc_ctl_t  ctl;
    tx_result_t res;
    logic [WP_W-1:0] bufp;

    logic run, irq_en, irq_st;
    logic [ADDR_W-1:RING_AW] ring_base;
    logic [IDX_W-1:0]        ring_idx;
    logic stop_req, adv_req, irq_set, beat;
    logic is_last, word_end;
    logic [ADDR_W-1:0] desc_addr;

    assign desc_addr = {ring_base, ring_idx, {DESC_LG{1'b0}}};
    assign beat      = tx_valid && tx_ready;
    assign stop_req  = (state == ST_HEAD) && mem_ack && !mem_rdata[OWN_POS];
    assign adv_req   = (state == ST_WBACK) && mem_ack;
    assign irq_set   = adv_req && ctl.irq_req && irq_en;

    txdma_regs #(.ADDR_W(ADDR_W), .RING_AW(RING_AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stop_req(stop_req), .adv_req(adv_req), .adv_wrap(ctl.wrap), .irq_set(irq_set),
        .run(run), .irq_en(irq_en), .irq_st(irq_st),
        .ring_base(ring_base), .ring_idx(ring_idx)
    );

    txdma_bytes #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_bytes (
        .clk(clk), .rst(rst),
        .len_load((state == ST_BUFP) && mem_ack), .len_in(ctl.len),
        .word_load((state == ST_FETCH) && mem_ack), .word_in(mem_rdata),
        .beat(beat), .byte_out(tx_data), .is_last(is_last), .word_end(word_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctl   <= '0;
            res   <= '0;
            bufp  <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (run) state <= ST_HEAD;
                ST_HEAD:  if (mem_ack) begin
                    ctl   <= unpack_ctl(mem_rdata);
                    state <= mem_rdata[OWN_POS] ? ST_BUFP : ST_IDLE;
                end
                ST_BUFP:  if (mem_ack) begin
                    bufp <= mem_rdata[ADDR_W-1:2];
                    res  <= '0;
                    state <= (ctl.len == '0) ? ST_WBACK : ST_FETCH;
                end
                ST_FETCH: if (mem_ack) state <= ST_SEND;
                ST_SEND:  if (beat) begin
                    if (is_last) begin
                        state <= ST_WAIT;
                    end else if (word_end) begin
                        bufp  <= bufp + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_WAIT:  if (done_valid) begin
                    res   <= '{attl: done_al, undr: done_ue};
                    state <= ST_WBACK;
                end
                ST_WBACK: if (mem_ack) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_HEAD:  begin mem_req = 1'b1; mem_addr = desc_addr; end
            ST_BUFP:  begin mem_req = 1'b1; mem_addr = desc_addr | ADDR_W'(4); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = {bufp, 2'b00}; end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = pack_status(ctl, res);
            end
            default: ;
        endcase
    end

    assign tx_valid = (state == ST_SEND);
    assign tx_last  = tx_valid && is_last;
    assign irq      = irq_st;

endmodule

// File: rtl/txdma_chk.sv
module txdma_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [IDX_W-1:0]  ring_idx
);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[11] && (mem_wdata[31:16] == 16'h0));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R4
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_last |=> !tx_valid);

    // R6 R7
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr) |=> $stable(ring_idx) || (ring_idx == '0) ||
                                  (ring_idx == IDX_W'($past(ring_idx) + 1'b1)));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ack));

endmodule

bind txdma_engine txdma_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .tx_data(tx_data), .irq(irq), .ring_idx(ring_idx)
);

// File: tb/tb_txdma_engine.sv
module tb_txdma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic        done_valid = 1'b0;
    logic        done_al, done_ue;
    logic        irq;

    logic        res_al = 1'b0, res_ue = 1'b0, ready_alt = 1'b0;
    assign done_al = res_al;
    assign done_ue = res_ue;

    always #2 clk = ~clk;   // 250 MHz

    txdma_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .done_valid(done_valid),
        .done_al(done_al), .done_ue(done_ue), .irq(irq)
    );

    // memory, stream sink and transmitter model
    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:255];
    logic [7:0]  cap [0:255];
    logic        cap_last [0:255];
    int rd_n = 0, data_rd_n = 0, cap_n = 0;
    int done_cd = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack    <= 1'b0;
            done_valid <= 1'b0;
            done_cd    <= 0;
            tx_ready   <= 1'b1;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[11:2]];
                if (!mem_we) begin
                    rd_log[rd_n[7:0]] <= mem_addr;
                    rd_n <= rd_n + 1;
                    if (mem_addr >= 32'h800) data_rd_n <= data_rd_n + 1;
                end
            end
            if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            if (tx_valid && tx_ready) begin
                cap[cap_n[7:0]]      <= tx_data;
                cap_last[cap_n[7:0]] <= tx_last;
                cap_n <= cap_n + 1;
            end
            tx_ready <= ready_alt ? ~tx_ready : 1'b1;
            if (tx_valid && tx_ready && tx_last) done_cd <= 3;
            else if (done_cd != 0) done_cd <= done_cd - 1;
            done_valid <= (done_cd == 1);
        end
    end

    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] c;
        for (int i = 0; i < 3000; i++) begin
            reg_read(1'b0, c);
            if (!c[0]) return;
        end
        check("R3 engine never stopped", 32'h1, 32'h0);
    endtask

    task automatic put_desc(int idx, logic [31:0] w0, logic [31:0] buf_a);
        mem[(32'h400 + idx * 8) >> 2]     = w0;
        mem[((32'h400 + idx * 8) >> 2) + 1] = buf_a;
    endtask

    task automatic t_reset();
        reg_read(1'b0, rv); check("R1 control", rv, 32'h0);
        reg_read(1'b1, rv); check("R1 pointer", rv, 32'h0);
        check("R1 outputs", {29'h0, mem_req, tx_valid, irq}, 32'h0);
    endtask

    task automatic t_basic();
        int r0, c0;
        reg_write(1'b1, 32'h400);
        put_desc(0, 32'h2806, 32'h800);
        put_desc(1, 32'h0, 32'h0);
        mem[32'h200] = 32'h11223344;
        mem[32'h201] = 32'h55667788;
        r0 = rd_n; c0 = cap_n;
        reg_write(1'b0, 32'h3);
        wait_stop();
        check("R2 head addr", rd_log[r0], 32'h400);
        check("R2 buffer-word addr", rd_log[r0 + 1], 32'h404);
        check("R4 data word 0 addr", rd_log[r0 + 2], 32'h800);
        check("R4 data word 1 addr", rd_log[r0 + 3], 32'h804);
        check("R6 next fetch addr", rd_log[r0 + 4], 32'h408);
        check("R4 byte count", cap_n - c0, 6);
        for (int i = 0; i < 6; i++) begin
            check("R4 byte order", cap[c0 + i], 32'h11 * (i + 1));
            check("R4 last flag", cap_last[c0 + i], (i == 5));
        end
        check("R5 write-back word", mem[32'h100], 32'h2006);
        check("R8 irq after success", irq, 1);
        reg_read(1'b1, rv); check("R6 pointer advanced", rv, 32'h408);
        reg_read(1'b0, rv); check("R3 run cleared", rv[0], 0);
        r0 = rd_n;
        repeat (20) @(negedge clk);
        check("R3 no requests after stop", rd_n - r0, 0);
    endtask

    task automatic t_w1c();
        reg_write(1'b0, 32'h2);
        reg_read(1'b0, rv); check("R9 write zero keeps status", rv[2], 1);
        reg_write(1'b0, 32'h6);
        reg_read(1'b0, rv); check("R9 write one clears status", rv[2], 0);
        check("R9 irq low after clear", irq, 0);
    endtask

    task automatic t_backpressure_wrap_flag();
        int c0;
        put_desc(1, 32'h1805, 32'h840);
        mem[32'h210] = 32'hA1B2C3D4;
        mem[32'h211] = 32'hE5F60708;
        ready_alt = 1'b1; res_al = 1'b1;
        c0 = cap_n;
        reg_write(1'b0, 32'h3);
        wait_stop();
        check("R11 byte count under backpressure", cap_n - c0, 5);
        check("R11 byte 0", cap[c0], 32'hA1);
        check("R11 byte 3", cap[c0 + 3], 32'hD4);
        check("R4 partial final word", cap[c0 + 4], 32'hE5);
        check("R4 last on final", cap_last[c0 + 4], 1);
        check("R5 attempt-limit write-back", mem[32'h102], 32'h9005);
        check("R8 no irq without request bit", irq, 0);
        reg_read(1'b1, rv); check("R7 wrap flag to zero", rv, 32'h400);
        ready_alt = 1'b0; res_al = 1'b0;
    endtask

    task automatic t_zero_len();
        int d0, c0;
        put_desc(0, 32'h2800, 32'h900);
        d0 = data_rd_n; c0 = cap_n;
        reg_write(1'b0, 32'h7);
        wait_stop();
        check("R10 no buffer reads", data_rd_n - d0, 0);
        check("R10 no stream bytes", cap_n - c0, 0);
        check("R10 write-back", mem[32'h100], 32'h2000);
        check("R10 irq raised", irq, 1);
        reg_read(1'b1, rv); check("R10 pointer advanced", rv, 32'h408);
    endtask

    task automatic t_end_wrap();
        int c0;
        reg_write(1'b1, 32'h7F8);
        mem[32'h1FE] = 32'h2801;
        mem[32'h1FF] = 32'hA00;
        mem[32'h280] = 32'h5A000000;
        res_ue = 1'b1;
        c0 = cap_n;
        reg_write(1'b0, 32'h7);
        wait_stop();
        check("R4 single byte", cap[c0], 32'h5A);
        check("R4 single byte last", cap_last[c0], 1);
        check("R5 underrun write-back", mem[32'h1FE], 32'h6001);
        check("R8 irq on error", irq, 1);
        reg_read(1'b1, rv); check("R7 wrap at final slot", rv, 32'h400);
        res_ue = 1'b0;
    endtask

    task automatic t_set_vs_clear();
        bit hit = 0;
        reg_write(1'b0, 32'h4);
        check("R9 cleared before race", irq, 0);
        put_desc(0, 32'h2802, 32'h800);
        reg_write(1'b0, 32'h3);
        for (int i = 0; i < 2000 && !hit; i++) begin
            @(negedge clk);
            if (mem_ack && mem_we) begin
                reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h7;
                hit = 1;
                @(negedge clk);
                reg_wr = 1'b0;
            end
        end
        check("R9 write-back seen", hit, 1);
        wait_stop();
        reg_read(1'b0, rv); check("R9 set wins over clear", rv[2], 1);
        check("R9 irq stays high", irq, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_w1c();
        t_backpressure_wrap_flag();
        t_zero_len();
        t_end_wrap();
        t_set_vs_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule